// File: doc/BRIEF.md
# Packed Sparse Systolic Matrix-Vector Array

This block multiplies a packed sparse matrix by a vector on a two-dimensional grid of processing elements. The matrix has been compressed column-wise beforehand: each grid column carries entries that came from several original columns. Every stored entry keeps a weight and the original column index it belongs to. Matrix rows are written one per cycle, in row order, into a second weight bank while the first bank is still in use. A load counter switches the write bank once a full block of rows has arrived.

For every grid column, the caller streams a group of vector beats from the top. Each beat carries an original column index and a value, and a closing end beat finishes the group. Beats move down one row per cycle. An element stores the value whose index matches its own tag. When the end beat reaches it, the element adds weight times stored value to the partial sum from its left neighbour and passes the result to the right. The caller starts the end beats of neighbouring columns at least one cycle apart, so the partial sums form a diagonal wave. The right edge is captured row by row, and the block raises a valid pulse once the bottom row is complete. Each element switches to its other weight bank after it has handled an end beat. The next block can therefore be loaded and streamed while the current one is still in flight.

Top module: `ssa_array`

## Requirements
- R1: While reset is high and in the first cycle after it, `res_valid` is low, the load row counter is 0 and the write bank is bank 0.
- R2: Each `ld_valid` cycle writes one matrix row, starting at row 0 and going up by one. Column c takes weight `ld_w[c*DW +: DW]` and tag `ld_idx[c*IDXW +: IDXW]`. After row ROWS-1 is written, the counter returns to 0 and the write bank switches.
- R3: An element keeps the value of a non-end beat whose index equals its tag, but only if its weight is non-zero. Beats with other indices leave the stored value unchanged.
- R4: A beat on column c is seen by row r exactly r cycles after row 0 sees it, so the end beat fires row r one cycle after row r-1.
- R5: When the end beat fires an element, its output is the left partial sum plus weight times stored value. A zero weight passes the left sum through unchanged, and an element with no match adds 0. Column 0 starts from 0.
- R6: If the end beat of column c is sampled at least one cycle after that of column c-1, each row's result equals the sum over its columns of that row's contributions from R5.
- R7: If the last column's end beat is sampled at clock edge e, `res_valid` is high in the cycle after edge e+ROWS. In that cycle `res_data[r*AW +: AW]` holds row r's result.
- R8: Every element switches to its other weight bank after handling an end beat. A block whose rows load while the previous block streams is therefore computed with its own weights, provided blocks keep their end beats at least max(ROWS, group length+1) cycles apart.
- R9: Handling an end beat clears the stored value. In a following block, an element that sees no match contributes 0 and nothing from the earlier block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_valid | input | 1 | Writes one matrix row this cycle |
| ld_w | input | COLS*DW | Row weights, one per grid column |
| ld_idx | input | COLS*IDXW | Original column tags of the row entries |
| vin_valid | input | COLS | Element beat present, per column |
| vin_idx | input | COLS*IDXW | Original column index of each beat |
| vin_val | input | COLS*DW | Vector value of each beat |
| vin_end | input | COLS | End-of-group beat, per column |
| res_valid | output | 1 | Result vector valid |
| res_data | output | ROWS*AW | One partial sum per matrix row |

## Verification
The bench works out the result of each block from its weights, tags and groups. It lays every load beat, vector beat and expected result on a timeline indexed by clock edge. The expected pulse sits ROWS edges after the edge at which the last column's end beat is sampled: ROWS-1 edges to travel down the column and one edge for the output capture. At every falling edge the bench compares `res_valid` with the timeline. In the cycles where a pulse is due, it also compares every row of `res_data`, so a result that arrives early or late shows up as a mismatch.

// File: rtl/ssa_pkg.sv
package ssa_pkg;
  typedef enum logic {BANK_A = 1'b0, BANK_B = 1'b1} bank_e;

  function automatic bank_e other_bank(bank_e b);
    return (b == BANK_A) ? BANK_B : BANK_A;
  endfunction
endpackage

// File: rtl/ssa_load_ctrl.sv
module ssa_load_ctrl
  import ssa_pkg::*;
#(
  parameter int ROWS = 4,
  localparam int RW = (ROWS > 1) ? $clog2(ROWS) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ld_valid,
  output logic [RW-1:0] row_q,
  output bank_e         bank_q,
  output logic [ROWS-1:0] row_we
);
  always_ff @(posedge clk) begin
    if (rst) begin
      row_q  <= '0;
      bank_q <= BANK_A;
    end else if (ld_valid) begin
      if (row_q == RW'(ROWS - 1)) begin
        row_q  <= '0;
        bank_q <= other_bank(bank_q);
      end else begin
        row_q <= row_q + 1'b1;
      end
    end
  end

  always_comb begin
    row_we = '0;
    for (int r = 0; r < ROWS; r++)
      if (ld_valid && row_q == RW'(r)) row_we[r] = 1'b1;
  end
endmodule

// File: rtl/ssa_pe.sv
module ssa_pe #(
  parameter int DW   = 8,
  parameter int IDXW = 4,
  parameter int AW   = 20
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            we,
  input  logic            wbank,
  input  logic [DW-1:0]   w_in,
  input  logic [IDXW-1:0] tag_in,
  input  logic            xv_i,
  input  logic [IDXW-1:0] xi_i,
  input  logic [DW-1:0]   xd_i,
  input  logic            xe_i,
  input  logic [AW-1:0]   ps_i,
  output logic            xv_o,
  output logic [IDXW-1:0] xi_o,
  output logic [DW-1:0]   xd_o,
  output logic            xe_o,
  output logic [AW-1:0]   ps_o,
  output logic            fire_o
);
  logic [DW-1:0]   w_mem   [2];
  logic [IDXW-1:0] tag_mem [2];
  logic            sel_q;
  logic [DW-1:0]   held_q;
  logic [DW-1:0]   w_cur;
  logic [IDXW-1:0] tag_cur;
  logic            hit;

  always_ff @(posedge clk) begin
    if (we) begin
      w_mem[wbank]   <= w_in;
      tag_mem[wbank] <= tag_in;
    end
  end

  assign w_cur   = w_mem[sel_q];
  assign tag_cur = tag_mem[sel_q];
  assign hit     = xv_i && !xe_i && (xi_i == tag_cur) && (w_cur != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q  <= 1'b0;
      held_q <= '0;
      xv_o   <= 1'b0;
      xe_o   <= 1'b0;
      xi_o   <= '0;
      xd_o   <= '0;
      ps_o   <= '0;
      fire_o <= 1'b0;
    end else begin
      xv_o   <= xv_i;
      xe_o   <= xe_i;
      xi_o   <= xi_i;
      xd_o   <= xd_i;
      fire_o <= xe_i;
      if (xe_i) begin
        if (w_cur == '0) ps_o <= ps_i;
        else             ps_o <= ps_i + (AW'(w_cur) * AW'(held_q));
        held_q <= '0;
        sel_q  <= ~sel_q;
      end else if (hit) begin
        held_q <= xd_i;
      end
    end
  end
endmodule

// File: rtl/ssa_drain.sv
module ssa_drain #(
  parameter int ROWS = 4,
  parameter int AW   = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ROWS-1:0]   fire_col,
  input  logic [ROWS*AW-1:0] ps_col,
  output logic              res_valid,
  output logic [ROWS*AW-1:0] res_data
);
  always_ff @(posedge clk) begin
    if (rst) res_valid <= 1'b0;
    else     res_valid <= fire_col[ROWS-1];
  end

  for (genvar r = 0; r < ROWS; r++) begin : g_cap
    always_ff @(posedge clk) begin
      if (rst)              res_data[r*AW +: AW] <= '0;
      else if (fire_col[r]) res_data[r*AW +: AW] <= ps_col[r*AW +: AW];
    end
  end
endmodule

// File: rtl/ssa_array.sv
module ssa_array
  import ssa_pkg::*;
#(
  parameter int ROWS = 4,
  parameter int COLS = 4,
  parameter int DW   = 8,
  parameter int IDXW = 4,
  parameter int AW   = 20,
  localparam int RW = (ROWS > 1) ? $clog2(ROWS) : 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 ld_valid,
  input  logic [COLS*DW-1:0]   ld_w,
  input  logic [COLS*IDXW-1:0] ld_idx,
  input  logic [COLS-1:0]      vin_valid,
  input  logic [COLS*IDXW-1:0] vin_idx,
  input  logic [COLS*DW-1:0]   vin_val,
  input  logic [COLS-1:0]      vin_end,
  output logic                 res_valid,
  output logic [ROWS*AW-1:0]   res_data
);
  logic [RW-1:0]   ld_row;
  bank_e           wr_bank;
  logic            wr_bank_bit;
  logic [ROWS-1:0] row_we;

  logic            xv [ROWS+1][COLS];
  logic            xe [ROWS+1][COLS];
  logic [IDXW-1:0] xi [ROWS+1][COLS];
  logic [DW-1:0]   xd [ROWS+1][COLS];
  logic [AW-1:0]   ps [ROWS][COLS+1];
  logic            fire [ROWS][COLS];
  logic [ROWS*COLS-1:0] fire_flat;
  logic [ROWS-1:0]      fire_col;
  logic [ROWS*AW-1:0]   ps_col;

  ssa_load_ctrl #(.ROWS(ROWS)) u_ctrl (
    .clk(clk), .rst(rst), .ld_valid(ld_valid),
    .row_q(ld_row), .bank_q(wr_bank), .row_we(row_we)
  );
  assign wr_bank_bit = (wr_bank == BANK_B);

  for (genvar c = 0; c < COLS; c++) begin : g_top
    assign xv[0][c] = vin_valid[c];
    assign xe[0][c] = vin_end[c];
    assign xi[0][c] = vin_idx[c*IDXW +: IDXW];
    assign xd[0][c] = vin_val[c*DW +: DW];
  end

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    assign ps[r][0] = '0;
    for (genvar c = 0; c < COLS; c++) begin : g_col
      ssa_pe #(.DW(DW), .IDXW(IDXW), .AW(AW)) u_pe (
        .clk(clk), .rst(rst),
        .we(row_we[r]), .wbank(wr_bank_bit),
        .w_in(ld_w[c*DW +: DW]), .tag_in(ld_idx[c*IDXW +: IDXW]),
        .xv_i(xv[r][c]), .xi_i(xi[r][c]), .xd_i(xd[r][c]), .xe_i(xe[r][c]),
        .ps_i(ps[r][c]),
        .xv_o(xv[r+1][c]), .xi_o(xi[r+1][c]), .xd_o(xd[r+1][c]), .xe_o(xe[r+1][c]),
        .ps_o(ps[r][c+1]), .fire_o(fire[r][c])
      );
      assign fire_flat[r*COLS+c] = fire[r][c];
    end
    assign fire_col[r]           = fire[r][COLS-1];
    assign ps_col[r*AW +: AW]    = ps[r][COLS];
  end

  ssa_drain #(.ROWS(ROWS), .AW(AW)) u_drain (
    .clk(clk), .rst(rst), .fire_col(fire_col), .ps_col(ps_col),
    .res_valid(res_valid), .res_data(res_data)
  );
endmodule

// File: rtl/ssa_checker.sv
module ssa_checker #(
  parameter int ROWS = 4,
  parameter int COLS = 4,
  localparam int RW = (ROWS > 1) ? $clog2(ROWS) : 1
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 ld_valid,
  input logic [RW-1:0]        ld_row,
  input logic                 wr_bank,
  input logic [ROWS*COLS-1:0] fire_flat,
  input logic                 res_valid
);
  assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!res_valid && ld_row == '0 && !wr_bank));

  assert_row_range_R2: assert property (@(posedge clk) disable iff (rst)
    ld_row <= RW'(ROWS - 1));

  assert_bank_swap_R2: assert property (@(posedge clk) disable iff (rst)
    (wr_bank != $past(wr_bank)) |-> ($past(ld_valid) && $past(ld_row) == RW'(ROWS - 1)));

  for (genvar r = 0; r < ROWS - 1; r++) begin : g_wr
    for (genvar c = 0; c < COLS; c++) begin : g_wc
      assert_wave_R4: assert property (@(posedge clk) disable iff (rst)
        fire_flat[(r+1)*COLS+c] |-> $past(fire_flat[r*COLS+c]));
    end
  end

  assert_result_R7: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> $past(fire_flat[ROWS*COLS-1]));
endmodule

bind ssa_array ssa_checker #(.ROWS(ROWS), .COLS(COLS)) u_chk (
  .clk(clk), .rst(rst), .ld_valid(ld_valid), .ld_row(ld_row),
  .wr_bank(wr_bank_bit), .fire_flat(fire_flat), .res_valid(res_valid)
);

// File: tb/tb_ssa_array.sv
`timescale 1ns/1ps
module tb_ssa_array;
  localparam int ROWS = 4, COLS = 4, DW = 8, IDXW = 4, AW = 20;
  localparam int L = 4, NB = 6, T = 110;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ld_valid = 1'b0;
  logic [COLS*DW-1:0]   ld_w = '0;
  logic [COLS*IDXW-1:0] ld_idx = '0;
  logic [COLS-1:0]      vin_valid = '0;
  logic [COLS*IDXW-1:0] vin_idx = '0;
  logic [COLS*DW-1:0]   vin_val = '0;
  logic [COLS-1:0]      vin_end = '0;
  logic                 res_valid;
  logic [ROWS*AW-1:0]   res_data;

  always #2.5 clk = ~clk;

  ssa_array #(.ROWS(ROWS), .COLS(COLS), .DW(DW), .IDXW(IDXW), .AW(AW)) dut (
    .clk(clk), .rst(rst), .ld_valid(ld_valid), .ld_w(ld_w), .ld_idx(ld_idx),
    .vin_valid(vin_valid), .vin_idx(vin_idx), .vin_val(vin_val), .vin_end(vin_end),
    .res_valid(res_valid), .res_data(res_data)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  int bw [NB][ROWS][COLS];
  int bi [NB][ROWS][COLS];
  int gi [NB][COLS][L];
  int gv [NB][COLS][L];
  int gl [NB][COLS];

  bit tl_ld [T];
  int tl_lb [T];
  int tl_lr [T];
  bit tl_v [T][COLS];
  bit tl_e [T][COLS];
  int tl_i [T][COLS];
  int tl_d [T][COLS];
  bit ex_v [T];
  int ex_y [T][ROWS];
  string ex_tag [T];

  task automatic check(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s cycle %0d: actual %0d expected %0d", tag, cyc, act, exp);
    end
  endtask

  task automatic build();
    for (int b = 0; b < NB; b++) begin
      for (int c = 0; c < COLS; c++) begin
        int base;
        base = $urandom_range(15);
        case (b)
          4:       gl[b][c] = L;
          5:       gl[b][c] = 1;
          default: gl[b][c] = $urandom_range(L, 1);
        endcase
        for (int k = 0; k < L; k++) begin
          gi[b][c][k] = (base + 3 * k) % 16;
          gv[b][c][k] = $urandom_range(255, 1);
        end
        for (int r = 0; r < ROWS; r++) begin
          bw[b][r][c] = $urandom_range(255, 1);
          if (b == 0 && $urandom_range(3) == 0) bw[b][r][c] = 0;
          if (b == 1 && (r % 2 == 0 || c == 1)) bw[b][r][c] = 0;
          if (b == 2)
            bi[b][r][c] = (base + 1) % 16;
          else if (b == 0 && $urandom_range(3) == 0)
            bi[b][r][c] = (base + 2) % 16;
          else
            bi[b][r][c] = gi[b][c][$urandom_range(gl[b][c] - 1)];
        end
      end
    end
  endtask

  task automatic schedule();
    for (int e = 0; e < T; e++) begin
      tl_ld[e] = 0; ex_v[e] = 0; ex_tag[e] = "";
      for (int c = 0; c < COLS; c++) begin
        tl_v[e][c] = 0; tl_e[e][c] = 0; tl_i[e][c] = 0; tl_d[e][c] = 0;
      end
    end
    for (int b = 0; b < NB; b++) begin
      int s, due;
      s = 20 + 9 * b;
      for (int r = 0; r < ROWS; r++) begin
        tl_ld[s - 5 + r] = 1; tl_lb[s - 5 + r] = b; tl_lr[s - 5 + r] = r;
      end
      for (int c = 0; c < COLS; c++) begin
        for (int k = 0; k < gl[b][c]; k++) begin
          tl_v[s + c + k][c] = 1;
          tl_i[s + c + k][c] = gi[b][c][k];
          tl_d[s + c + k][c] = gv[b][c][k];
        end
        tl_e[s + c + L][c] = 1;
      end
      due = s + (COLS - 1) + L + ROWS;
      ex_v[due] = 1;
      case (b)
        0: ex_tag[due] = "R5 R6";
        1: ex_tag[due] = "R5";
        2: ex_tag[due] = "R9";
        3: ex_tag[due] = "R3";
        4: ex_tag[due] = "R8";
        default: ex_tag[due] = "R2 R8";
      endcase
      for (int r = 0; r < ROWS; r++) begin
        int sum;
        sum = 0;
        for (int c = 0; c < COLS; c++) begin
          if (bw[b][r][c] != 0)
            for (int k = 0; k < gl[b][c]; k++)
              if (gi[b][c][k] == bi[b][r][c]) sum += bw[b][r][c] * gv[b][c][k];
        end
        ex_y[due][r] = sum;
      end
    end
  endtask

  task automatic drive(int e);
    ld_valid = tl_ld[e];
    for (int c = 0; c < COLS; c++) begin
      ld_w[c*DW +: DW]       = tl_ld[e] ? DW'(bw[tl_lb[e]][tl_lr[e]][c]) : '0;
      ld_idx[c*IDXW +: IDXW] = tl_ld[e] ? IDXW'(bi[tl_lb[e]][tl_lr[e]][c]) : '0;
      vin_valid[c]           = tl_v[e][c];
      vin_end[c]             = tl_e[e][c];
      vin_idx[c*IDXW +: IDXW] = IDXW'(tl_i[e][c]);
      vin_val[c*DW +: DW]     = DW'(tl_d[e][c]);
    end
  endtask

  initial begin
    build();
    schedule();
    drive(0);
    @(negedge clk);
    check("R1 res_valid in reset", int'(res_valid), 0);
    while (cyc < T - 2) begin
      if (cyc == 4) rst = 1'b0;
      if (cyc == 5) check("R1 res_valid after reset", int'(res_valid), 0);
      if (cyc >= 1) begin
        check("R4 R7 valid timing", int'(res_valid), int'(ex_v[cyc]));
        if (ex_v[cyc])
          for (int r = 0; r < ROWS; r++)
            check(ex_tag[cyc], int'(res_data[r*AW +: AW]), ex_y[cyc][r]);
      end
      drive(cyc + 1);
      @(negedge clk);
    end
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule